// File: doc/BRIEF.md
# CAN Transmit Mailbox Status Register

This block holds the transmit outcome of three CAN transmit mailboxes in one 32-bit register. The transmit engine reports per-mailbox event pulses: a transmission started, it finished cleanly, it finished with an error, arbitration was lost, it was aborted, or the mailbox became empty. The block turns these pulses into sticky flags that software reads back and clears by writing ones.

Software writes through a 32-bit data word with four byte strobes. Byte lane i belongs to mailbox i, and lane 3 is unused. Software can also set a per-mailbox stop bit that asks the engine to stop transmitting. The stop bit is presented on a dedicated output, and hardware clears it once the mailbox is empty. Raising a mailbox's transmit-request input clears that mailbox's finished flag.

Top module: `txmb_status`

## Requirements
- R1: Mailbox i (0..2) occupies bits 8i+7:8i. Within a lane, bit 0 is the finished flag, bit 1 is the clean-finish flag, bit 2 is the arbitration-lost flag, bit 3 is the error flag and bit 7 is the stop bit. A write reaches lane i only when write strobe bit i is high.
- R2: The finished flag is set by a clean finish, an error finish or an abort. It is cleared by writing 1 to bit 0, or while that mailbox's transmit-request input is high.
- R3: The error flag is set by an error finish. It is cleared by writing 1 to bit 3, by writing 1 to bit 0, or by a transmission start in that mailbox.
- R4: The arbitration-lost flag is set by an arbitration-lost event. It is cleared by writing 1 to bit 2, by writing 1 to bit 0, or by a transmission start in that mailbox.
- R5: The clean-finish flag is set by a clean finish. It is cleared by writing 1 to bit 1, by writing 1 to bit 0, or by an error finish.
- R6: When a set event and a clear condition reach the same flag in the same cycle, the flag ends up set.
- R7: Bits 6:4 of every lane and bits 31:24 always read 0, and writes to them are ignored. Writing 0 to a flag bit leaves that flag unchanged.
- R8: The stop bit is set by writing 1 to bit 7. Writing 0 to it has no effect. It is cleared when the mailbox-empty event arrives, but a same-cycle software set wins. The stop_req output bit i equals mailbox i's stop bit.
- R9: An active-low synchronous reset clears the whole register. Every event or write shows on rd_data in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_be | input | 4 | Byte write strobes |
| wr_data | input | 32 | Write data |
| tx_req | input | 3 | Per-mailbox transmit request |
| ev_start | input | 3 | Transmission started |
| ev_done_ok | input | 3 | Transmission finished without error |
| ev_done_err | input | 3 | Transmission finished with error |
| ev_arb_lost | input | 3 | Arbitration lost |
| ev_abort | input | 3 | Transmission aborted |
| ev_empty | input | 3 | Mailbox became empty |
| rd_data | output | 32 | Packed register value |
| stop_req | output | 3 | Per-mailbox stop request |

## Verification
The hardest cases to reach are the same-cycle collisions, where a set event and a clearing write, or a start and an error finish, hit one flag together. Each rule settles them differently. The bench drives the engine pulse and the register write in the same cycle and then reads the lane back. A second hard case is the error finish that arrives while the clean-finish flag is already set. The bench creates it by running a clean finish and then an error finish back to back on the same mailbox.

// File: rtl/txmb_status.sv
module txmb_status #(
  parameter int NMB = 3,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW/8-1:0]   wr_be,
  input  logic [DW-1:0]     wr_data,
  input  logic [NMB-1:0]    tx_req,
  input  logic [NMB-1:0]    ev_start,
  input  logic [NMB-1:0]    ev_done_ok,
  input  logic [NMB-1:0]    ev_done_err,
  input  logic [NMB-1:0]    ev_arb_lost,
  input  logic [NMB-1:0]    ev_abort,
  input  logic [NMB-1:0]    ev_empty,
  output logic [DW-1:0]     rd_data,
  output logic [NMB-1:0]    stop_req
);
  localparam int LANE = 8;

  logic [NMB-1:0] fin_q, ok_q, arb_q, err_q, stp_q;

  for (genvar i = 0; i < NMB; i++) begin : g_mb
    logic       lane_we;
    logic [7:0] d;
    logic       fin_set, fin_clr, ok_set, ok_clr, arb_set, arb_clr, err_set, err_clr;

    assign lane_we = wr_en & wr_be[i];
    assign d       = wr_data[i*LANE +: LANE];

    assign fin_set = ev_done_ok[i] | ev_done_err[i] | ev_abort[i];
    assign fin_clr = (lane_we & d[0]) | tx_req[i];
    assign ok_set  = ev_done_ok[i];
    assign ok_clr  = (lane_we & (d[1] | d[0])) | ev_done_err[i];
    assign arb_set = ev_arb_lost[i];
    assign arb_clr = (lane_we & (d[2] | d[0])) | ev_start[i];
    assign err_set = ev_done_err[i];
    assign err_clr = (lane_we & (d[3] | d[0])) | ev_start[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fin_q[i] <= 1'b0;
        ok_q[i]  <= 1'b0;
        arb_q[i] <= 1'b0;
        err_q[i] <= 1'b0;
        stp_q[i] <= 1'b0;
      end else begin
        fin_q[i] <= fin_set | (fin_q[i] & ~fin_clr);
        ok_q[i]  <= ok_set  | (ok_q[i]  & ~ok_clr);
        arb_q[i] <= arb_set | (arb_q[i] & ~arb_clr);
        err_q[i] <= err_set | (err_q[i] & ~err_clr);
        stp_q[i] <= (lane_we & d[7]) | (stp_q[i] & ~ev_empty[i]);
      end
    end

    assign rd_data[i*LANE +: LANE] = {stp_q[i], 3'b000, err_q[i], arb_q[i], ok_q[i], fin_q[i]};

    assert_fin_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done_ok[i] | ev_done_err[i] | ev_abort[i]) |=> rd_data[i*LANE]);
    assert_err_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start[i] & ~ev_done_err[i]) |=> !rd_data[i*LANE+3]);
    assert_arb_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_arb_lost[i] |=> rd_data[i*LANE+2]);
    assert_ok_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done_err[i] & ~ev_done_ok[i]) |=> !rd_data[i*LANE+1]);
    assert_stop_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_req[i]) |-> $past(ev_empty[i]));
    assert_ok_needs_fin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done_ok[i] & wr_en & wr_be[i]) |=> (rd_data[i*LANE+1] & rd_data[i*LANE]));
  end

  assign rd_data[DW-1:NMB*LANE] = '0;
  assign stop_req = stp_q;
endmodule

// File: tb/sim_txmb_status.sv
`timescale 1ns/1ps
module sim_txmb_status;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [2:0] tx_req = 0, ev_start = 0, ev_done_ok = 0, ev_done_err = 0;
  logic [2:0] ev_arb_lost = 0, ev_abort = 0, ev_empty = 0;
  logic [31:0] rd_data;
  logic [2:0] stop_req;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  txmb_status u0 (.clk, .rst_n, .wr_en, .wr_be, .wr_data, .tx_req, .ev_start,
    .ev_done_ok, .ev_done_err, .ev_arb_lost, .ev_abort, .ev_empty, .rd_data, .stop_req);

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wr_en = 0; wr_be = 0; wr_data = 0; tx_req = 0; ev_start = 0; ev_done_ok = 0;
    ev_done_err = 0; ev_arb_lost = 0; ev_abort = 0; ev_empty = 0;
  endtask

  task automatic step();
    cyc(); idle();
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    wr_en = 1; wr_be = be; wr_data = d; step();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R9 reset rd_data", rd_data, 0);
    chk("R9 reset stop_req", {29'd0, stop_req}, 0);
  endtask

  task automatic t_clean_finish();
    ev_done_ok = 3'b001; step();
    chk("R2 R5 clean finish sets bits 0,1", rd_data, 32'h03);
    wr(4'b0001, 32'h02);
    chk("R5 w1c clean-finish only", rd_data, 32'h01);
    wr(4'b0001, 32'h00);
    chk("R7 writing zero no effect", rd_data, 32'h01);
    tx_req = 3'b001; step();
    chk("R2 tx_req clears finished", rd_data, 32'h00);
  endtask

  task automatic t_error_path();
    ev_done_ok = 3'b010; step();
    ev_done_err = 3'b010; step();
    chk("R5 R3 error finish drops clean flag", rd_data, 32'h0900);
    ev_arb_lost = 3'b010; step();
    chk("R4 arbitration lost sets bit 2", rd_data, 32'h0D00);
    wr(4'b0010, 32'h0100);
    chk("R3 R4 R5 w1c finished cross-clears", rd_data, 32'h0000);
  endtask

  task automatic t_start_clears();
    ev_done_err = 3'b100; ev_arb_lost = 3'b100; step();
    chk("R3 R4 lane 2 error and arb", rd_data, 32'h0D0000);
    ev_start = 3'b100; step();
    chk("R3 R4 start clears error and arb", rd_data, 32'h010000);
    wr(4'b0100, 32'h04_0000);
    chk("R4 w1c arb bit when already clear", rd_data, 32'h010000);
    ev_abort = 3'b100; ev_start = 3'b100; step();
    chk("R2 abort sets finished", rd_data, 32'h010000);
    wr(4'b0100, 32'h01_0000);
  endtask

  task automatic t_stop();
    wr(4'b0001, 32'h80);
    chk("R8 stop set", rd_data, 32'h80);
    chk("R8 stop_req follows", {29'd0, stop_req}, 32'h1);
    wr(4'b0001, 32'h00);
    chk("R8 writing zero keeps stop", {29'd0, stop_req}, 32'h1);
    ev_empty = 3'b001; step();
    chk("R8 empty clears stop", {29'd0, stop_req}, 0);
    ev_empty = 3'b010; wr_en = 1; wr_be = 4'b0010; wr_data = 32'h8000; step();
    chk("R8 set wins over empty", {29'd0, stop_req}, 32'h2);
    ev_empty = 3'b010; step();
  endtask

  task automatic t_reserved();
    wr(4'b1111, 32'hFFFF_FFFF);
    chk("R7 reserved read zero", rd_data, 32'h0080_8080);
    ev_empty = 3'b111; step();
    chk("R7 clear after reserved write", rd_data, 0);
  endtask

  task automatic t_collision();
    ev_done_err = 3'b010; wr_en = 1; wr_be = 4'b0010; wr_data = 32'h0F00; step();
    chk("R6 set wins over w1c", rd_data, 32'h0900);
    ev_done_ok = 3'b001; tx_req = 3'b001; step();
    chk("R6 finished set wins over tx_req", rd_data[7:0], 8'h03);
    wr(4'b0011, 32'h0101);
  endtask

  task automatic t_lanes();
    ev_abort = 3'b111; step();
    chk("R1 abort on all lanes", rd_data, 32'h010101);
    wr(4'b0010, 32'h0101_0101);
    chk("R1 strobe gates lane", rd_data, 32'h010001);
    wr(4'b0000, 32'hFFFF_FFFF);
    chk("R1 no strobe no write", rd_data, 32'h010001);
  endtask

  initial begin
    idle();
    repeat (3) cyc();
    t_reset();
    rst_n = 1; cyc();
    t_clean_finish();
    t_error_path();
    t_start_clears();
    t_stop();
    t_reserved();
    t_collision();
    t_lanes();
    rst_n = 0; step();
    chk("R9 reset clears after use", rd_data, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R9 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule